// File: doc/BRIEF.md
# Free-Running Timer with Input Capture and Output Compare

This peripheral keeps one 16-bit counter that runs without pause from reset, advancing once per prescaler tick. Two functions share that count. An input-capture channel watches an external line and, when it sees the chosen edge, stores the count of that moment in a capture register. An output-compare channel checks a software-loaded compare value against the count on every tick. On equality it sets a flag and drives an output pin to a level that software chose in advance.

A CPU reaches the block over a narrow byte-wide register bus with a 3-bit address. Each 16-bit quantity is split into a high and a low byte. A read of the counter's high byte freezes the low byte, so the two halves of a count that is moving still belong together. A write of the compare value's high byte is only held; the low-byte write loads both halves at once. Three status flags (capture, compare, wrap) are cleared by writing ones to them. Each flag has its own enable, and together they drive a single interrupt request line.

Top module: `capcmp_timer`

## Requirements
- R1: The counter resets to 0x0000 and advances by exactly one on every prescaler tick (every clock with the default divide of 1), wrapping from 0xFFFF to 0x0000; bus writes to addresses 2 and 3 leave it unchanged.
- R2: A read of address 2 returns the counter's upper byte and stores its lower byte at the same clock edge; a later read of address 3 returns that stored byte, so back-to-back counter reads that start at count V then return V+2.
- R3: CTRL bit 0 selects the capture edge (1 = rising, 0 = falling); the line passes through two synchronising flops, and the capture register (address 4 upper byte, 5 lower byte) takes the counter value two clocks after the line changes, while the opposite edge captures nothing.
- R4: Each capture sets the capture flag, STATUS bit 0.
- R5: When the counter equals the compare value on a tick, the compare flag (STATUS bit 1) is set at the following clock edge.
- R6: On a compare match the output pin takes the level of CTRL bit 1 at the following clock edge and holds that level at all other times.
- R7: A write to address 6 only stages the compare upper byte; a write to address 7 loads the staged byte and the new lower byte together, and the new value is used from the next tick on. No match is signalled in the cycle of that write, even when the old compare value equals the count.
- R8: When the counter wraps from 0xFFFF to 0x0000 the wrap flag, STATUS bit 2, is set.
- R9: Writing a 1 to a STATUS bit clears that flag and writing a 0 leaves it alone; a new event in the same cycle as the clear wins.
- R10: The interrupt output is high whenever a flag is set with its enable set: CTRL bit 4 for capture, bit 5 for compare, bit 6 for wrap.
- R11: While reset is held the output pin and the interrupt are low, and STATUS and the counter read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with the clock |
| cap_in | input | 1 | External capture line, not synchronous to clk |
| bus_addr | input | 3 | Register address: 0 CTRL, 1 STATUS, 2/3 counter, 4/5 capture, 6/7 compare |
| bus_wr | input | 1 | Write strobe for one clock |
| bus_rd | input | 1 | Read strobe; needed only for the counter upper-byte latch |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| cmp_out | output | 1 | Output-compare pin |
| irq | output | 1 | Interrupt request |

## Verification
A compare match found while the counter holds T shows on the flag and on the pin one clock later, so the bench checks that both are still clear while the count is T and set in the next cycle. A capture stores the count from two clocks after the line changed, and a wrap shows on its flag in the cycle where the count is 0x0000. Writes to STATUS and CTRL take effect in the next cycle. Each bus operation in the bench takes exactly one clock, starting on a falling edge, so the bench knows the count from its own cycle arithmetic after a single counter read and samples every result on the falling edge of the cycle in which it is due.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;
  localparam logic [2:0] A_CTRL   = 3'd0;
  localparam logic [2:0] A_STATUS = 3'd1;
  localparam logic [2:0] A_CNT_HI = 3'd2;
  localparam logic [2:0] A_CNT_LO = 3'd3;
  localparam logic [2:0] A_CAP_HI = 3'd4;
  localparam logic [2:0] A_CAP_LO = 3'd5;
  localparam logic [2:0] A_CMP_HI = 3'd6;
  localparam logic [2:0] A_CMP_LO = 3'd7;

  localparam int B_EDGE_RISE = 0;
  localparam int B_OUT_LEVEL = 1;
  localparam int B_IE_CAP    = 4;
  localparam int B_IE_CMP    = 5;
  localparam int B_IE_WRAP   = 6;

  localparam int F_CAP  = 0;
  localparam int F_CMP  = 1;
  localparam int F_WRAP = 2;

  typedef struct packed {
    logic ie_wrap;
    logic ie_cmp;
    logic ie_cap;
    logic out_level;
    logic edge_rise;
  } ctrl_t;
endpackage

// File: rtl/capcmp_counter.sv
module capcmp_counter #(
  parameter int CNT_W = 16,
  parameter int DIV   = 1,
  localparam int HALF = CNT_W / 2
) (
  input  logic             clk,
  input  logic             rst_i,
  input  logic             rd_hi,
  output logic [CNT_W-1:0] cnt,
  output logic             tick,
  output logic             wrap_evt,
  output logic [HALF-1:0]  lo_latch
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [HALF-1:0]  lo_q, lo_d;

  generate
    if (DIV <= 1) begin : g_nodiv
      assign tick = 1'b1;
    end else begin : g_div
      localparam int PRE_W = $clog2(DIV);
      logic [PRE_W-1:0] pre_q, pre_d;
      assign tick = (pre_q == PRE_W'(DIV - 1));
      always_comb pre_d = tick ? '0 : pre_q + 1'b1;
      always_ff @(posedge clk or negedge rst_i) begin
        if (!rst_i) pre_q <= '0;
        else        pre_q <= pre_d;
      end
    end
  endgenerate

  always_comb begin
    cnt_d = cnt_q;
    if (tick) cnt_d = cnt_q + 1'b1;
    lo_d = lo_q;
    if (rd_hi) lo_d = cnt_q[HALF-1:0];
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      cnt_q <= '0;
      lo_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      lo_q  <= lo_d;
    end
  end

  assign cnt      = cnt_q;
  assign lo_latch = lo_q;
  assign wrap_evt = tick && (cnt_q == {CNT_W{1'b1}});

  assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_i)
    tick |=> cnt_q == $past(cnt_q) + 1'b1);
  assert_count_hold_R1: assert property (@(posedge clk) disable iff (!rst_i)
    !tick |=> $stable(cnt_q));
  assert_lo_snapshot_R2: assert property (@(posedge clk) disable iff (!rst_i)
    rd_hi |=> lo_q == $past(cnt_q[HALF-1:0]));
endmodule

// File: rtl/capcmp_capture.sv
module capcmp_capture #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_i,
  input  logic             cap_in,
  input  logic             edge_rise,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cap_val,
  output logic             cap_evt
);
  logic sync1_q, sync2_q, prev_q;
  logic [CNT_W-1:0] cap_q, cap_d;

  always_comb begin
    cap_evt = edge_rise ? (sync2_q && !prev_q) : (!sync2_q && prev_q);
    cap_d   = cap_evt ? cnt : cap_q;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      prev_q  <= 1'b0;
      cap_q   <= '0;
    end else begin
      sync1_q <= cap_in;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
      cap_q   <= cap_d;
    end
  end

  assign cap_val = cap_q;

  assert_capture_takes_count_R3: assert property (@(posedge clk) disable iff (!rst_i)
    cap_evt |=> cap_q == $past(cnt));
  assert_capture_holds_R3: assert property (@(posedge clk) disable iff (!rst_i)
    !cap_evt |=> $stable(cap_q));
endmodule

// File: rtl/capcmp_compare.sv
module capcmp_compare #(
  parameter int CNT_W = 16,
  localparam int HALF = CNT_W / 2
) (
  input  logic             clk,
  input  logic             rst_i,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt,
  input  logic             wr_hi,
  input  logic             wr_lo,
  input  logic [HALF-1:0]  wdata,
  input  logic             level,
  output logic [CNT_W-1:0] cmp_val,
  output logic             match_evt,
  output logic             pin
);
  logic [HALF-1:0]  stage_q, stage_d;
  logic [CNT_W-1:0] cmp_q, cmp_d;
  logic             pin_q, pin_d;

  always_comb begin
    match_evt = tick && (cnt == cmp_q) && !wr_lo;
    stage_d   = wr_hi ? wdata : stage_q;
    cmp_d     = wr_lo ? {stage_q, wdata} : cmp_q;
    pin_d     = match_evt ? level : pin_q;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      stage_q <= '0;
      cmp_q   <= '0;
      pin_q   <= 1'b0;
    end else begin
      stage_q <= stage_d;
      cmp_q   <= cmp_d;
      pin_q   <= pin_d;
    end
  end

  assign cmp_val = cmp_q;
  assign pin     = pin_q;

  assert_pin_level_R6: assert property (@(posedge clk) disable iff (!rst_i)
    match_evt |=> pin_q == $past(level));
  assert_pin_steady_R6: assert property (@(posedge clk) disable iff (!rst_i)
    !match_evt |=> $stable(pin_q));
  assert_no_match_on_write_R7: assert property (@(posedge clk) disable iff (!rst_i)
    wr_lo |-> !match_evt);
  assert_cmp_only_on_low_R7: assert property (@(posedge clk) disable iff (!rst_i)
    !wr_lo |=> $stable(cmp_q));
endmodule

// File: rtl/capcmp_timer.sv
module capcmp_timer #(
  parameter int CNT_W = 16,
  parameter int DIV   = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cap_in,
  input  logic [2:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       cmp_out,
  output logic       irq
);
  import capcmp_pkg::*;
  localparam int HALF = CNT_W / 2;

  logic [1:0] rst_sync_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1] && rst_n;

  logic [CNT_W-1:0] cnt, cap_val, cmp_val;
  logic [HALF-1:0]  lo_latch;
  logic             tick, wrap_evt, cap_evt, match_evt;
  logic             rd_hi, wr_ctrl, wr_stat, wr_cmp_hi, wr_cmp_lo;
  ctrl_t            ctrl_q, ctrl_d;
  logic [2:0]       flag_q, flag_d, flag_set;

  always_comb begin
    rd_hi     = bus_rd && (bus_addr == A_CNT_HI);
    wr_ctrl   = bus_wr && (bus_addr == A_CTRL);
    wr_stat   = bus_wr && (bus_addr == A_STATUS);
    wr_cmp_hi = bus_wr && (bus_addr == A_CMP_HI);
    wr_cmp_lo = bus_wr && (bus_addr == A_CMP_LO);
  end

  capcmp_counter #(.CNT_W(CNT_W), .DIV(DIV)) u_counter (
    .clk(clk), .rst_i(rst_i), .rd_hi(rd_hi), .cnt(cnt),
    .tick(tick), .wrap_evt(wrap_evt), .lo_latch(lo_latch));

  capcmp_capture #(.CNT_W(CNT_W)) u_capture (
    .clk(clk), .rst_i(rst_i), .cap_in(cap_in), .edge_rise(ctrl_q.edge_rise),
    .cnt(cnt), .cap_val(cap_val), .cap_evt(cap_evt));

  capcmp_compare #(.CNT_W(CNT_W)) u_compare (
    .clk(clk), .rst_i(rst_i), .tick(tick), .cnt(cnt),
    .wr_hi(wr_cmp_hi), .wr_lo(wr_cmp_lo), .wdata(bus_wdata[HALF-1:0]),
    .level(ctrl_q.out_level), .cmp_val(cmp_val), .match_evt(match_evt),
    .pin(cmp_out));

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) begin
      ctrl_d.edge_rise = bus_wdata[B_EDGE_RISE];
      ctrl_d.out_level = bus_wdata[B_OUT_LEVEL];
      ctrl_d.ie_cap    = bus_wdata[B_IE_CAP];
      ctrl_d.ie_cmp    = bus_wdata[B_IE_CMP];
      ctrl_d.ie_wrap   = bus_wdata[B_IE_WRAP];
    end
    flag_set = '0;
    flag_set[F_CAP]  = cap_evt;
    flag_set[F_CMP]  = match_evt;
    flag_set[F_WRAP] = wrap_evt;
    flag_d = flag_q;
    if (wr_stat) flag_d = flag_q & ~bus_wdata[2:0];
    flag_d = flag_d | flag_set;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      ctrl_q <= '0;
      flag_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      flag_q <= flag_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: begin
        bus_rdata[B_EDGE_RISE] = ctrl_q.edge_rise;
        bus_rdata[B_OUT_LEVEL] = ctrl_q.out_level;
        bus_rdata[B_IE_CAP]    = ctrl_q.ie_cap;
        bus_rdata[B_IE_CMP]    = ctrl_q.ie_cmp;
        bus_rdata[B_IE_WRAP]   = ctrl_q.ie_wrap;
      end
      A_STATUS: bus_rdata[2:0] = flag_q;
      A_CNT_HI: bus_rdata = cnt[CNT_W-1:HALF];
      A_CNT_LO: bus_rdata = lo_latch;
      A_CAP_HI: bus_rdata = cap_val[CNT_W-1:HALF];
      A_CAP_LO: bus_rdata = cap_val[HALF-1:0];
      A_CMP_HI: bus_rdata = cmp_val[CNT_W-1:HALF];
      default:  bus_rdata = cmp_val[HALF-1:0];
    endcase
  end

  assign irq = (flag_q[F_CAP]  && ctrl_q.ie_cap) ||
               (flag_q[F_CMP]  && ctrl_q.ie_cmp) ||
               (flag_q[F_WRAP] && ctrl_q.ie_wrap);

  assert_cap_flag_R4: assert property (@(posedge clk) disable iff (!rst_i)
    cap_evt |=> flag_q[F_CAP]);
  assert_cmp_flag_R5: assert property (@(posedge clk) disable iff (!rst_i)
    match_evt |=> flag_q[F_CMP]);
  assert_wrap_flag_R8: assert property (@(posedge clk) disable iff (!rst_i)
    wrap_evt |=> flag_q[F_WRAP]);
  assert_w1c_clears_R9: assert property (@(posedge clk) disable iff (!rst_i)
    (wr_stat && bus_wdata[F_CAP] && !cap_evt) |=> !flag_q[F_CAP]);
  assert_w0_keeps_R9: assert property (@(posedge clk) disable iff (!rst_i)
    (flag_q[F_WRAP] && !(wr_stat && bus_wdata[F_WRAP])) |=> flag_q[F_WRAP]);
  assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_i)
    (flag_q == 3'b000) |-> !irq);
  always_comb begin
    if (!rst_n) assert_reset_quiet_R11: assert (!irq && !cmp_out);
  end
endmodule

// File: tb/capcmp_timer_bench.sv
module capcmp_timer_bench;
  logic       clk;
  logic       rst_n;
  logic       cap_in;
  logic [2:0] bus_addr;
  logic       bus_wr;
  logic       bus_rd;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       cmp_out;
  logic       irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  capcmp_timer u_capcmp_timer (
    .clk(clk), .rst_n(rst_n), .cap_in(cap_in), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cmp_out(cmp_out), .irq(irq));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // fields: {edge_rise, start level, end level, capture expected}
  localparam logic [3:0] CAP_VEC [4] = '{4'b1011, 4'b0101, 4'b1100, 4'b0010};

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one bus operation = one clock, entered and left just after a falling edge
  task automatic bus_op(input logic [2:0] a, input logic w, input logic r,
                        input logic [7:0] d, output logic [7:0] q);
    bus_addr = a; bus_wr = w; bus_rd = r; bus_wdata = d;
    #1 q = bus_rdata;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    logic [7:0] q;
    bus_op(a, 1'b1, 1'b0, d, q);
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] q);
    bus_addr = a; bus_wr = 1'b0; bus_rd = 1'b0;
    #1 q = bus_rdata;
  endtask

  // returns the count of the first cycle; two cycles elapse
  task automatic read_cnt(output logic [15:0] v, input logic drive, input logic lvl);
    logic [7:0] hi, lo;
    if (drive) cap_in = lvl;
    bus_op(3'd2, 1'b0, 1'b1, 8'h00, hi);
    bus_op(3'd3, 1'b0, 1'b1, 8'h00, lo);
    v = {hi, lo};
  endtask

  task automatic read_cap(output logic [15:0] v);
    logic [7:0] hi, lo;
    peek(3'd4, hi);
    peek(3'd5, lo);
    v = {hi, lo};
  endtask

  task automatic skip(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog R1..R11 actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0]  q;
    logic [15:0] v, v2, old_cap, cap;
    rst_n = 1'b0; cap_in = 1'b0;
    bus_addr = 3'd0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = 8'h00;
    skip(3);
    // R11: reset state
    check("R11 pin in reset", {15'd0, cmp_out}, 16'd0);
    check("R11 irq in reset", {15'd0, irq}, 16'd0);
    peek(3'd1, q); check("R11 status in reset", {8'd0, q}, 16'd0);
    peek(3'd2, q); check("R11 count in reset", {8'd0, q}, 16'd0);
    rst_n = 1'b1;
    skip(4);

    // R2: two consecutive counter reads are two clocks apart
    read_cnt(v, 1'b0, 1'b0);
    read_cnt(v2, 1'b0, 1'b0);
    check("R2 paired byte read", v2, v + 16'd2);

    // R1: writes to counter addresses do not disturb it
    read_cnt(v, 1'b0, 1'b0);
    wr(3'd2, 8'h55);
    wr(3'd3, 8'hAA);
    read_cnt(v2, 1'b0, 1'b0);
    check("R1 count ignores writes", v2, v + 16'd4);

    // R3/R4: capture edge table
    foreach (CAP_VEC[i]) begin
      logic [3:0] e;
      e = CAP_VEC[i];
      wr(3'd0, {7'd0, e[3]});
      cap_in = e[2];
      skip(5);
      wr(3'd1, 8'h07);
      read_cap(old_cap);
      read_cnt(v, 1'b1, e[1]);
      skip(3);
      peek(3'd1, q);
      check("R4 capture flag", {15'd0, q[0]}, {15'd0, e[0]});
      read_cap(cap);
      check("R3 captured count", cap, e[0] ? v + 16'd2 : old_cap);
    end

    // R5/R6/R7: compare runs driving level 1 then 0
    for (int k = 0; k < 2; k++) begin
      logic lvl;
      lvl = (k == 0);
      wr(3'd0, {6'd0, lvl, 1'b1});
      wr(3'd1, 8'h07);
      read_cnt(v, 1'b0, 1'b0);
      v2 = v + 16'd10;
      wr(3'd6, v2[15:8]);
      wr(3'd7, v2[7:0]);
      skip(6);
      peek(3'd1, q);
      check("R5 no flag before match", {15'd0, q[1]}, 16'd0);
      check("R6 pin before match", {15'd0, cmp_out}, {15'd0, ~lvl});
      skip(1);
      peek(3'd1, q);
      check("R5 flag after match", {15'd0, q[1]}, 16'd1);
      check("R6 pin after match", {15'd0, cmp_out}, {15'd0, lvl});
    end

    // R7: staged high byte, and no match in the low-byte write cycle
    wr(3'd0, 8'h03);
    read_cnt(v, 1'b0, 1'b0);
    wr(3'd1, 8'h07);
    v2 = v + 16'd8;
    wr(3'd6, v2[15:8]);
    wr(3'd7, v2[7:0]);
    v2 = v + 16'd1000;
    wr(3'd6, v2[15:8]);
    skip(2);
    wr(3'd7, v2[7:0]);
    peek(3'd1, q);
    check("R7 no match in write cycle", {15'd0, q[1]}, 16'd0);
    check("R7 pin untouched", {15'd0, cmp_out}, 16'd0);
    peek(3'd6, q); check("R7 new compare high", {8'd0, q}, {8'd0, v2[15:8]});
    peek(3'd7, q); check("R7 new compare low", {8'd0, q}, {8'd0, v2[7:0]});

    // R9/R10: capture flag drives irq only when enabled
    cap_in = 1'b0; skip(4);
    wr(3'd1, 8'h07);
    cap_in = 1'b1; skip(4);
    check("R10 irq masked", {15'd0, irq}, 16'd0);
    wr(3'd0, 8'h11);
    check("R10 irq enabled", {15'd0, irq}, 16'd1);
    wr(3'd1, 8'h00);
    check("R9 zero write keeps flag", {15'd0, irq}, 16'd1);
    wr(3'd1, 8'h01);
    check("R9 one write clears flag", {15'd0, irq}, 16'd0);

    // R8: wrap flag
    wr(3'd0, 8'h41);
    wr(3'd1, 8'h07);
    read_cnt(v, 1'b0, 1'b0);
    skip(int'(16'hFFFF - (v + 16'd2)));
    peek(3'd1, q);
    check("R8 no wrap flag at 0xFFFF", {15'd0, q[2]}, 16'd0);
    skip(1);
    peek(3'd1, q);
    check("R8 wrap flag at 0x0000", {15'd0, q[2]}, 16'd1);
    check("R10 irq on wrap", {15'd0, irq}, 16'd1);
    read_cnt(v, 1'b0, 1'b0);
    check("R1 count after wrap", v, 16'd0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule